// File: doc/BRIEF.md
# General-Purpose I/O Bank with Set/Clear Output Control

This block gives software control of a bank of 32 general-purpose pins through a four-word register file on a simple synchronous bus. Each pin has a direction bit and an output latch bit, and its sampled input level can be read back. Line n of a larger pin space belongs to bank n/32 and occupies bit n mod 32 of every register in that bank. Several instances are placed side by side to cover wider pin spaces.

Software never changes the output latch with a read-modify-write. It writes a mask to a set register, which raises the masked bits, or to a clear register, which lowers them. Bits outside the mask are not touched. The latch drives `pin_out` at all times, whatever the pin's direction. Software can therefore load the wanted level first and then turn the pin into an output, and the pin drives that level from its first cycle as an output. Pin inputs pass through a two-flop synchronizer before software can read them, so a level change shows up only after a short delay.

Register word addresses are `addr` 0 for direction, 1 for set, 2 for clear and 3 for input data. The other addresses are unmapped.

Top module: `gpio_bank`

## Requirements
- R1: After reset the direction register reads all ones and the output latch is zero. `pin_oe` and `pin_out` are both all zeros.
- R2: A write to address 1 sets every output latch bit that is 1 in `wdata`. All other latch bits keep their value. `pin_out` shows the result after the write's clock edge.
- R3: A write to address 2 clears every output latch bit that is 1 in `wdata`. All other latch bits keep their value.
- R4: Address 0 is the read/write direction register. A 1 bit means the pin is an input and its driver is off (`pin_oe` bit 0). A 0 bit means the pin is an output (`pin_oe` bit 1).
- R5: The output latch drives `pin_out` regardless of direction. A level preset through set/clear appears on the pin in the same cycle that its direction bit changes to output.
- R6: A read of address 3 returns `pin_in` through two flops. A level that is present before clock edge k is readable after edge k+1 and is not yet visible after edge k.
- R7: A read of address 1 or address 2 returns the current output latch value.
- R8: Writes to address 3 or to any unmapped address change no state. Reads of unmapped addresses return zero.
- R9: A cycle with `wr_en` low changes no register, whatever `addr` and `wdata` hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W (4) | Register word address |
| wr_en | input | 1 | Write strobe for the current cycle |
| wdata | input | WIDTH (32) | Write data or bit mask |
| rdata | output | WIDTH (32) | Read data for `addr`, combinational |
| pin_in | input | WIDTH (32) | Pad input levels, asynchronous |
| pin_out | output | WIDTH (32) | Output latch value to the pads |
| pin_oe | output | WIDTH (32) | Pad output enables, 1 = drive |

## Verification
Register writes act on the clock edge at which `wr_en` is sampled, so the new latch, direction and enables are due one edge after the write. Reads are combinational and are due in the same cycle that `addr` is presented. An input change is due on the read path two edges after it is applied. The bench checks a first read after one edge to confirm that the old value is still shown, then a second read after another edge to confirm that the new value has arrived. Every stimulus is driven at a falling edge, and every sample is taken shortly after a falling edge. Each expected value therefore lands at a known edge count.

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int WIDTH  = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe
);

  localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_IN  = ADDR_W'(3);

  logic [WIDTH-1:0] dir_q, out_q, meta_q, sync_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= '1;
      out_q <= '0;
    end else if (wr_en) begin
      case (addr)
        A_DIR:   dir_q <= wdata;
        A_SET:   out_q <= out_q | wdata;
        A_CLR:   out_q <= out_q & ~wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pin_in;
      sync_q <= meta_q;
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = ~dir_q;

  always_comb begin
    case (addr)
      A_DIR:        rdata = dir_q;
      A_SET, A_CLR: rdata = out_q;
      A_IN:         rdata = sync_q;
      default:      rdata = '0;
    endcase
  end

  logic [1:0] live_q;
  always_ff @(posedge clk) begin
    if (!rst_n)             live_q <= 2'd0;
    else if (live_q != 2'd2) live_q <= live_q + 2'd1;
  end

  a_r2_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_SET) |=> ((pin_out & $past(wdata)) == $past(wdata)));

  a_r2_set_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_SET) |=> ((pin_out & ~$past(wdata)) == ($past(pin_out) & ~$past(wdata))));

  a_r3_clr_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CLR) |=> ((pin_out & $past(wdata)) == '0));

  a_r3_clr_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CLR) |=> ((pin_out | $past(wdata)) == ($past(pin_out) | $past(wdata))));

  a_r4_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_DIR) |=> (pin_oe == ~$past(wdata)));

  a_r6_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q == 2'd2 && addr == A_IN) |-> (rdata == $past(pin_in, 2)));

  a_r8_unmapped_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr != A_DIR && addr != A_SET && addr != A_CLR) |=> ($stable(pin_out) && $stable(pin_oe)));

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en) |=> ($stable(pin_out) && $stable(pin_oe)));

endmodule

// File: tb/gpio_bank_tb.sv
`timescale 1ns/1ps
module gpio_bank_tb;
  localparam logic [3:0] A_DIR = 4'd0, A_SET = 4'd1, A_CLR = 4'd2, A_IN = 4'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, pin_out, pin_oe;
  logic [31:0] pin_in = '0;

  int vecs = 0, errs = 0;
  bit done = 1'b0;
  logic [31:0] m_out, m_dir;

  always #2.5 clk = ~clk;

  gpio_bank #(.WIDTH(32), .ADDR_W(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_DIR, v); chk("R1 dir", v, 32'hffff_ffff);
    rd(A_SET, v); chk("R1 latch", v, 32'h0);
    chk("R1 pin_oe", pin_oe, 32'h0);
    chk("R1 pin_out", pin_out, 32'h0);
  endtask

  task automatic t_set();
    logic [31:0] v;
    wr(A_SET, 32'ha5a5_0f0f); m_out = 32'ha5a5_0f0f;
    chk("R2 set first", pin_out, m_out);
    wr(A_SET, 32'h0000_00f0); m_out |= 32'h0000_00f0;
    chk("R2 set merge", pin_out, m_out);
    rd(A_SET, v); chk("R7 read set addr", v, m_out);
  endtask

  task automatic t_clr();
    logic [31:0] v;
    wr(A_CLR, 32'h8000_0f01); m_out &= ~32'h8000_0f01;
    chk("R3 clear", pin_out, m_out);
    rd(A_CLR, v); chk("R7 read clr addr", v, m_out);
    wr(A_CLR, 32'h0); chk("R3 empty mask", pin_out, m_out);
  endtask

  task automatic t_dir();
    logic [31:0] v;
    wr(A_DIR, 32'hffff_0000); m_dir = 32'hffff_0000;
    chk("R4 pin_oe", pin_oe, ~m_dir);
    rd(A_DIR, v); chk("R4 dir readback", v, m_dir);
  endtask

  task automatic t_preset();
    wr(A_DIR, 32'hffff_ffff); m_dir = '1;
    wr(A_CLR, 32'hffff_ffff); m_out = '0;
    wr(A_SET, 32'h8000_0001); m_out = 32'h8000_0001;
    chk("R5 latch drives while input", pin_out, m_out);
    chk("R5 still tri-stated", pin_oe, 32'h0);
    wr(A_DIR, 32'h7fff_fffe); m_dir = 32'h7fff_fffe;
    chk("R5 driven level at enable", pin_out & pin_oe, 32'h8000_0001);
  endtask

  task automatic t_sync(input logic [31:0] pat);
    logic [31:0] old, v;
    rd(A_IN, old);
    @(negedge clk); addr = A_IN; pin_in = pat;
    @(negedge clk); #1 chk("R6 not after one edge", rdata, old);
    @(negedge clk); #1 chk("R6 visible after two edges", rdata, pat);
    rd(A_IN, v); chk("R6 stable", v, pat);
  endtask

  task automatic t_ignore();
    logic [31:0] v;
    wr(A_IN, 32'hffff_ffff);
    chk("R8 in-addr write latch", pin_out, m_out);
    chk("R8 in-addr write dir", pin_oe, ~m_dir);
    wr(4'd5, 32'hffff_ffff);
    wr(4'd15, 32'h0);
    chk("R8 unmapped latch", pin_out, m_out);
    chk("R8 unmapped dir", pin_oe, ~m_dir);
    rd(4'd5, v); chk("R8 unmapped read", v, 32'h0);
    @(negedge clk); addr = A_SET; wdata = 32'h5555_5555; wr_en = 1'b0;
    @(negedge clk); chk("R9 idle set", pin_out, m_out);
    addr = A_DIR; wdata = 32'h0;
    @(negedge clk); chk("R9 idle dir", pin_oe, ~m_dir);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  endtask

  initial begin
    m_out = '0; m_dir = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_set();
    t_clr();
    t_dir();
    t_preset();
    t_sync(32'hdead_beef);
    t_sync(32'h1234_5678);
    t_sync(32'h0);
    t_ignore();
    finish_run();
  end

  initial begin
    #(5ns * 20000);
    if (!done) begin
      vecs++; errs++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end
endmodule